// File: doc/BRIEF.md
# Auto-Decrementing Serial Register Loader

A three-wire serial slave, with a serial clock, a serial data line and a latch-enable line, that turns shifted-in bits into byte writes for a byte-wide register file. All three lines are synchronised into the system clock domain. Bits are taken MSB first on each rising serial clock edge while latch enable is low. A frame opens with a 16-bit register address. Every following 8-bit group becomes one byte write.

The first byte goes to the addressed register. While latch enable stays low, each further byte goes one address lower. A multi-byte field can therefore be loaded from its top byte down in a single burst, and the whole map can be loaded in one frame. Raising latch enable ends the frame and drops any byte that is only partly shifted in.

The block drives a one-cycle write strobe with address and data for every byte that lands on an implemented register. It also drives two dedicated strobes. One fires on a write to the feedback-divider low byte, which starts the sweep engine and the lock-speed-up timer. The other fires on a write that sets the software-reset bit.

Top module: `sreg_loader`

## Requirements
- R1: With latch enable low, 16 address bits followed by 8 data bits, all sampled MSB first on rising serial clock edges, produce one write with exactly that address and byte.
- R2: Each further 8 bits in the same frame are written to the address one lower than the previous byte's address.
- R3: Once a byte has been written to address 0, all further bytes in that frame are discarded.
- R4: Only the implemented addresses 0, 2, 16 to 39, 58 to 84 and 86 to 141 produce a write strobe. A byte aimed at any other address, including every address with bit 15 set, is ignored, but it still uses up its place in the downward sequence.
- R5: `start_o` pulses for exactly the cycle in which a byte is written to address 16, and at no other time.
- R6: `soft_rst_o` pulses together with a write to address 2 whose data bit 2 is 1. A write to address 2 with bit 2 clear gives no pulse.
- R7: Raising latch enable aborts a partly received byte without writing it. This also holds when the rise coincides with the serial clock edge that carries the byte's eighth bit. The next frame starts again with an address.
- R8: Serial clock edges while latch enable is high have no effect.
- R9: During and directly after reset, all strobes are low.
- R10: Each write strobe lasts one system clock cycle, with at most one strobe per received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| latch_i | input | 1 | Latch enable; high ends the frame |
| wr_en_o | output | 1 | One-cycle byte write strobe |
| wr_addr_o | output | 16 | Register address of the write |
| wr_data_o | output | 8 | Byte written |
| start_o | output | 1 | Pulse on a write to the divider low byte |
| soft_rst_o | output | 1 | Pulse on a write that sets the reset bit |

## Verification
Two things can arrive in the same synchronised cycle: a rising latch enable and the serial clock edge that completes a byte. The bench raises both lines on the same system-clock cycle for the eighth data bit. Both pass through identical synchroniser chains, so they reach the frame logic together. The check passes only if no write strobe appears and the following frame writes exactly its own single byte. A second coincidence is a write to address 16 or address 2: the dedicated strobe must fall in the same cycle as the write strobe. This is judged by counting strobes per frame and by a bound checker that ties the two together.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_DROP} phase_e;

  // implemented register windows; everything else is reserved
  localparam int LAST_REG = 141;
  localparam int GAP0_LO  = 3;
  localparam int GAP0_HI  = 15;
  localparam int GAP1_LO  = 40;
  localparam int GAP1_HI  = 57;
  localparam int GAP2     = 85;

  function automatic logic reg_present(input logic [ADDR_W-1:0] a);
    int unsigned v;
    v = int'(a);
    if (v > LAST_REG)                  return 1'b0;
    if (v == 1 || v == GAP2)           return 1'b0;
    if (v >= GAP0_LO && v <= GAP0_HI)  return 1'b0;
    if (v >= GAP1_LO && v <= GAP1_HI)  return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sreg_shift.sv
module sreg_shift
  import sreg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          latch_i,
  output logic          evt_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int CNT_W = $clog2(AW);

  phase_e          phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]   sh_q, cur_q;
  logic            sclk_q;
  logic            rise;
  logic [AW-1:0]   sh_nxt;

  assign rise   = sclk_i && !sclk_q;
  assign sh_nxt = {sh_q[AW-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      cur_q   <= '0;
      sclk_q  <= 1'b0;
      evt_o   <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      sclk_q <= sclk_i;
      evt_o  <= 1'b0;
      if (latch_i) begin
        // latch wins over a coincident clock edge: partial byte dropped
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end else if (rise) begin
        unique case (phase_q)
          PH_ADDR: begin
            sh_q <= sh_nxt;
            if (cnt_q == CNT_W'(AW-1)) begin
              cur_q   <= sh_nxt;
              cnt_q   <= '0;
              phase_q <= PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DATA: begin
            sh_q <= sh_nxt;
            if (cnt_q == CNT_W'(DW-1)) begin
              evt_o  <= 1'b1;
              addr_o <= cur_q;
              data_o <= sh_nxt[DW-1:0];
              cnt_q  <= '0;
              if (cur_q == '0) phase_q <= PH_DROP;
              else             cur_q   <= cur_q - 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int START_ADDR = 16,
  parameter int SRST_ADDR  = 2,
  parameter int SRST_BIT   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          start_o,
  output logic          soft_rst_o
);
  logic hit;
  assign hit = evt_i && reg_present(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      start_o    <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      wr_en_o    <= hit;
      start_o    <= hit && (addr_i == AW'(START_ADDR));
      soft_rst_o <= hit && (addr_i == AW'(SRST_ADDR)) && data_i[SRST_BIT];
      if (hit) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
  import sreg_pkg::*;
#(
  parameter int AW          = ADDR_W,
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2,
  parameter int START_ADDR  = 16,
  parameter int SRST_ADDR   = 2,
  parameter int SRST_BIT    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          latch_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          start_o,
  output logic          soft_rst_o
);
  logic [2:0]    pins_s;
  logic          evt;
  logic [AW-1:0] evt_addr;
  logic [DW-1:0] evt_data;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_i, sdata_i, sclk_i}),
    .q_o   (pins_s)
  );

  sreg_shift #(.AW(AW), .DW(DW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (pins_s[0]),
    .sdata_i(pins_s[1]),
    .latch_i(pins_s[2]),
    .evt_o  (evt),
    .addr_o (evt_addr),
    .data_o (evt_data)
  );

  sreg_decode #(
    .AW(AW), .DW(DW), .START_ADDR(START_ADDR),
    .SRST_ADDR(SRST_ADDR), .SRST_BIT(SRST_BIT)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .addr_i    (evt_addr),
    .data_i    (evt_data),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .start_o   (start_o),
    .soft_rst_o(soft_rst_o)
  );
endmodule

// File: rtl/sreg_loader_chk.sv
module sreg_loader_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          start_o,
  input logic          soft_rst_o
);
  p_start_with_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> wr_en_o && wr_addr_o == AW'(16));

  p_srst_with_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> wr_en_o && wr_addr_o == AW'(2) && wr_data_o[2]);

  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_no_high_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wr_addr_o[AW-1] && wr_addr_o != AW'(1));

  p_quiet_after_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wr_en_o && !start_o && !soft_rst_o);
endmodule

bind sreg_loader sreg_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .start_o   (start_o),
  .soft_rst_o(soft_rst_o)
);

// File: tb/tb_sreg_loader.sv
module tb_sreg_loader;
  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdata = 0, latch = 1;
  logic        wr_en, start, srst;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int errors = 0, checks = 0;
  logic finished = 0;
  int wcnt = 0, scnt = 0, rcnt = 0, dbl = 0;
  logic [15:0] log_a [16];
  logic [7:0]  log_d [16];
  logic prev_we = 0;

  always #4 clk = ~clk;

  sreg_loader dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .latch_i(latch),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .start_o(start), .soft_rst_o(srst)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wcnt < 16) begin log_a[wcnt] = wr_addr; log_d[wcnt] = wr_data; end
      wcnt++;
      if (prev_we) dbl++;
    end
    if (start) scnt++;
    if (srst) rcnt++;
    prev_we = wr_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    wcnt = 0; scnt = 0; rcnt = 0; dbl = 0;
  endtask

  task automatic bit_out(input logic b);
    sdata = b;
    repeat (3) @(posedge clk);
    sclk = 1;
    repeat (4) @(posedge clk);
    sclk = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic send(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic frame(input logic [15:0] a, input logic [23:0] d, input int nb);
    latch = 0;
    repeat (4) @(posedge clk);
    send({8'h0, a}, 16);
    send(d, 8 * nb);
    repeat (2) @(posedge clk);
    latch = 1;
    repeat (10) @(posedge clk);
  endtask

  function automatic bit present(input int a);
    return a == 0 || a == 2 || (a >= 16 && a <= 39) || (a >= 58 && a <= 84) ||
           (a >= 86 && a <= 141);
  endfunction

  // {addr, data, byte count}
  localparam logic [47:0] VEC [8] = '{
    {16'h0010, 24'h000064, 8'd1},
    {16'h0015, 24'hA1B2C3, 8'd3},
    {16'h0001, 24'h5A6B7C, 8'd3},
    {16'h0002, 24'h000004, 8'd1},
    {16'h0002, 24'h000003, 8'd1},
    {16'h8010, 24'h0000EE, 8'd1},
    {16'h0029, 24'h00C3D4, 8'd2},
    {16'h0012, 24'h112233, 8'd3}
  };
  localparam string TAG [8] = '{"R1 R5", "R2", "R3 R4", "R6", "R6",
                                "R4", "R4", "R2 R5"};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset strobes", int'({wr_en, start, srst}), 0);
    rst_ni = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 after reset", int'({wr_en, start, srst}), 0);

    foreach (VEC[k]) begin
      logic [15:0] a; logic [23:0] d; int nb, e, es, er;
      {a, d, nb} = {VEC[k][47:32], VEC[k][31:8], int'(VEC[k][7:0])};
      clr();
      frame(a, d, nb);
      e = 0; es = 0; er = 0;
      for (int i = 0; i < nb; i++) begin
        int ta; logic [7:0] b;
        ta = int'(a) - i;
        if (ta < 0) break;
        b = 8'(d >> (8 * (nb - 1 - i)));
        if (present(ta)) begin
          if (e < 16) begin
            chk({TAG[k], " addr"}, int'(log_a[e]), ta);
            chk({TAG[k], " data"}, int'(log_d[e]), int'(b));
          end
          if (ta == 16) es++;
          if (ta == 2 && b[2]) er++;
          e++;
        end
      end
      chk({TAG[k], " write count"}, wcnt, e);
      chk({TAG[k], " start count"}, scnt, es);
      chk({TAG[k], " srst count"}, rcnt, er);
      chk("R10 strobe width", dbl, 0);
    end

    // R7: abort mid-byte, then a clean frame
    clr();
    latch = 0;
    repeat (4) @(posedge clk);
    send(24'h0014, 16);
    send(24'h1F, 5);
    latch = 1;
    repeat (10) @(posedge clk);
    chk("R7 abort no write", wcnt, 0);
    frame(16'h0014, 24'h55, 1);
    chk("R7 next frame count", wcnt, 1);
    chk("R7 next frame addr", int'(log_a[0]), 20);
    chk("R7 next frame data", int'(log_d[0]), 'h55);

    // R7: latch rise coincides with eighth data bit edge
    clr();
    latch = 0;
    repeat (4) @(posedge clk);
    send(24'h0010, 16);
    send(24'h7F, 7);
    sdata = 1;
    repeat (3) @(posedge clk);
    sclk = 1; latch = 1;
    repeat (4) @(posedge clk);
    sclk = 0;
    repeat (10) @(posedge clk);
    chk("R7 coincident no write", wcnt, 0);
    chk("R7 coincident no start", scnt, 0);
    frame(16'h0013, 24'h9C, 1);
    chk("R7 coincident follow count", wcnt, 1);
    chk("R7 coincident follow addr", int'(log_a[0]), 19);

    // R8: clocking while latch high
    clr();
    for (int i = 0; i < 30; i++) begin
      sdata = i[0];
      repeat (2) @(posedge clk);
      sclk = 1;
      repeat (2) @(posedge clk);
      sclk = 0;
    end
    repeat (8) @(posedge clk);
    chk("R8 no write while latched", wcnt, 0);
    frame(16'h0016, 24'h11, 1);
    chk("R8 following frame count", wcnt, 1);
    chk("R8 following frame addr", int'(log_a[0]), 22);
    chk("R8 following frame data", int'(log_d[0]), 'h11);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule